// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block is the transmit half of one asynchronous serial channel. A host loads a byte into a one-entry holding register. The transmitter moves that byte into its shift register during the start bit. It then drives a frame onto the line: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Bit timing comes from an external clock-enable pulse, `bclk_en`. Each bit lasts sixteen pulses in oversampled mode and one pulse in single-rate mode.

Separate one-cycle commands enable and disable the transmitter. A disable that arrives before the byte has reached the shift register throws that byte away. A disable that arrives later lets the byte already in the shift register finish, and drops any byte still waiting in the holding register.

An optional active-low clear-to-send input can hold back new characters. It is consulted only between characters, so a frame that has started always completes. Two status outputs report the channel state. `tx_rdy` means the holding register can take another byte. `tx_emt` means both the holding register and the shift register are empty.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, `txd` is 1, `tx_rdy` is 0 and `tx_emt` is 1. While no frame is in progress, `txd` stays 1.
- R2: A frame is one start bit at 0, then eight data bits with bit 0 first, then one stop bit at 1. Each bit lasts 16 `bclk_en` pulses when `mode_1x` is 0 and 1 pulse when `mode_1x` is 1. `txd` changes only on a clock edge where `bclk_en` is high, or on a disable that aborts a frame.
- R3: The holding register is copied into the shift register on the third pulse of the start bit in 16x mode, and on the start bit's only pulse in 1x mode. `tx_rdy` rises in the cycle after the last pulse of the start bit, which is 16 pulses after `txd` falls in 16x mode and 1 pulse after in 1x mode.
- R4: A write accepted while `tx_rdy` is 1 makes `tx_rdy` 0 on the next cycle. `tx_rdy` is 0 while the transmitter is disabled. A write made while disabled is ignored and is never sent.
- R5: `tx_emt` is 1 right after an enable with nothing loaded, and again once the last frame has ended (underrun). It is 0 while a byte waits in the holding register or a frame is being shifted. When `tx_emt` is 1, `txd` is 1.
- R6: A disable that arrives before the copy point discards the loaded byte and returns `txd` to 1 at once. In 16x mode the line is low for at most three pulses, which is not a valid frame. This includes a disable issued immediately after a load while the transmitter was in underrun.
- R7: A disable that arrives after the copy point lets the frame in the shift register complete. It also discards any byte still in the holding register.
- R8: When `cts_ctrl` is 1, a new frame starts only while `cts_n` is 0. If `cts_n` rises during a frame, that frame completes and the next byte waits until `cts_n` returns to 0.
- R9: When `cts_ctrl` is 0, `cts_n` has no effect on transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_en | input | 1 | Bit-clock enable pulse |
| mode_1x | input | 1 | 1: one pulse per bit; 0: sixteen pulses per bit |
| cts_ctrl | input | 1 | 1: clear-to-send gates the start of each frame |
| cts_n | input | 1 | Clear-to-send, active low |
| tx_enable_cmd | input | 1 | One-cycle enable command |
| tx_disable_cmd | input | 1 | One-cycle disable command; wins over enable |
| thr_wr | input | 1 | Holding-register write strobe |
| thr_data | input | 8 | Byte to load |
| txd | output | 1 | Serial line, idle high |
| tx_rdy | output | 1 | Holding register can accept a byte |
| tx_emt | output | 1 | Holding and shift registers both empty |

## Verification
The hardest case to reach is a disable that lands inside the start bit but before the copy point. The bench reaches it by loading a byte, watching for `txd` to fall, and then issuing the disable within the same bit-clock period. It does this in both rate modes. To cover the opposite side of the copy point, the bench waits five pulses into the start bit before disabling; that frame must complete. A line receiver in the bench samples at mid-bit, so the short runt low caused by an abort is rejected rather than decoded. A clear-to-send rise in the middle of a frame is combined with a second queued byte, which shows that the gate acts only between frames.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    // Serial line level for a given state and current shift-register LSB.
    function automatic logic line_level(input tx_state_e st, input logic lsb);
        case (st)
            TX_START: line_level = 1'b0;
            TX_DATA:  line_level = lsb;
            default:  line_level = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int OVERSAMPLE = 16,
    parameter int XFER_TICK  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic mode_1x,
    input  logic run,
    input  logic in_start,
    output logic bit_end,
    output logic xfer_pt
);
    localparam int CW = $clog2(OVERSAMPLE);

    logic [CW-1:0] sub_q;

    assign bit_end = tick && (mode_1x || sub_q == CW'(OVERSAMPLE - 1));
    assign xfer_pt = in_start && tick && (mode_1x || sub_q == CW'(XFER_TICK - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sub_q <= '0;
        end else if (tick) begin
            sub_q <= bit_end ? '0 : sub_q + CW'(1);
        end
    end

endmodule

// File: rtl/uart_tx_holding.sv
module uart_tx_holding #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         take,
    input  logic         drop,
    output logic         valid,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (drop) begin
            valid <= 1'b0;
        end else if (wr) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
    import uart_tx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16,
    parameter int XFER_TICK  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bclk_en,
    input  logic                 mode_1x,
    input  logic                 cts_ctrl,
    input  logic                 cts_n,
    input  logic                 tx_enable_cmd,
    input  logic                 tx_disable_cmd,
    input  logic                 thr_wr,
    input  logic [DATA_BITS-1:0] thr_data,
    output logic                 txd,
    output logic                 tx_rdy,
    output logic                 tx_emt
);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    tx_state_e            state_q;
    logic                 en_q;
    logic                 sh_loaded_q;
    logic [DATA_BITS-1:0] sh_q;
    logic [BW-1:0]        bidx_q;

    logic                 hold_v;
    logic [DATA_BITS-1:0] hold_d;
    logic                 bit_end, xfer_pt;
    logic                 wr_ok, cts_ok, launch, abort_chr, take;

    assign wr_ok     = thr_wr && en_q && !tx_disable_cmd;
    assign cts_ok    = !cts_ctrl || !cts_n;
    assign launch    = en_q && !tx_disable_cmd && hold_v && cts_ok;
    assign abort_chr = (state_q == TX_START) && !sh_loaded_q && tx_disable_cmd;
    assign take      = xfer_pt && !tx_disable_cmd;

    uart_tx_bit_timer #(
        .OVERSAMPLE(OVERSAMPLE),
        .XFER_TICK (XFER_TICK)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (bclk_en),
        .mode_1x (mode_1x),
        .run     (state_q != TX_IDLE),
        .in_start(state_q == TX_START),
        .bit_end (bit_end),
        .xfer_pt (xfer_pt)
    );

    uart_tx_holding #(
        .W(DATA_BITS)
    ) u_hold (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr_ok),
        .din  (thr_data),
        .take (take),
        .drop (tx_disable_cmd),
        .valid(hold_v),
        .dout (hold_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (tx_disable_cmd) begin
            en_q <= 1'b0;
        end else if (tx_enable_cmd) begin
            en_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= TX_IDLE;
            sh_loaded_q <= 1'b0;
            sh_q        <= '0;
            bidx_q      <= '0;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (bclk_en && launch) begin
                        state_q     <= TX_START;
                        sh_loaded_q <= 1'b0;
                    end
                end
                TX_START: begin
                    if (abort_chr) begin
                        state_q <= TX_IDLE;
                    end else begin
                        if (take) begin
                            sh_q        <= hold_d;
                            sh_loaded_q <= 1'b1;
                        end
                        if (bit_end) begin
                            state_q <= TX_DATA;
                            bidx_q  <= '0;
                        end
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        sh_q <= sh_q >> 1;
                        if (bidx_q == BW'(DATA_BITS - 1)) begin
                            state_q <= TX_STOP;
                        end else begin
                            bidx_q <= bidx_q + BW'(1);
                        end
                    end
                end
                default: begin
                    if (bit_end) begin
                        if (launch) begin
                            state_q     <= TX_START;
                            sh_loaded_q <= 1'b0;
                        end else begin
                            state_q <= TX_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    assign txd    = line_level(state_q, sh_q[0]);
    assign tx_rdy = en_q && !hold_v && (state_q != TX_START);
    assign tx_emt = (state_q == TX_IDLE) && !hold_v;

endmodule

// File: rtl/uart_tx_cts_chk.sv
module uart_tx_cts_chk (
    input logic clk,
    input logic rst,
    input logic bclk_en,
    input logic cts_ctrl,
    input logic cts_n,
    input logic tx_enable_cmd,
    input logic tx_disable_cmd,
    input logic thr_wr,
    input logic txd,
    input logic tx_rdy,
    input logic tx_emt
);
    // R2
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !bclk_en && !tx_disable_cmd |=> $stable(txd));

    // R3
    rdy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_rdy) |-> ($past(bclk_en) || $past(tx_enable_cmd)));

    // R4
    rdy_clears_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        tx_rdy && thr_wr && !tx_disable_cmd |=> !tx_rdy);

    // R4
    rdy_low_after_disable_chk: assert property (@(posedge clk) disable iff (rst)
        tx_disable_cmd |=> !tx_rdy);

    // R5
    empty_means_mark_chk: assert property (@(posedge clk) disable iff (rst)
        tx_emt |-> txd);

    // R8
    cts_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
        cts_ctrl && cts_n && tx_emt |=> txd);

endmodule

bind uart_tx_cts uart_tx_cts_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bclk_en       (bclk_en),
    .cts_ctrl      (cts_ctrl),
    .cts_n         (cts_n),
    .tx_enable_cmd (tx_enable_cmd),
    .tx_disable_cmd(tx_disable_cmd),
    .thr_wr        (thr_wr),
    .txd           (txd),
    .tx_rdy        (tx_rdy),
    .tx_emt        (tx_emt)
);

// File: tb/tb_uart_tx_cts.sv
module tb_uart_tx_cts;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk_en = 1'b0;
    logic       mode_1x = 1'b0;
    logic       cts_ctrl = 1'b0;
    logic       cts_n = 1'b0;
    logic       tx_enable_cmd = 1'b0;
    logic       tx_disable_cmd = 1'b0;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_data = 8'h00;
    logic       txd, tx_rdy, tx_emt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int div = 16;
    int tcnt = 0;

    logic [7:0] rx_q[$];
    logic [7:0] exp_q[$];
    int         frame_err = 0;

    always #2 clk = ~clk;

    uart_tx_cts dut (
        .clk           (clk),
        .rst           (rst),
        .bclk_en       (bclk_en),
        .mode_1x       (mode_1x),
        .cts_ctrl      (cts_ctrl),
        .cts_n         (cts_n),
        .tx_enable_cmd (tx_enable_cmd),
        .tx_disable_cmd(tx_disable_cmd),
        .thr_wr        (thr_wr),
        .thr_data      (thr_data),
        .txd           (txd),
        .tx_rdy        (tx_rdy),
        .tx_emt        (tx_emt)
    );

    // bit-clock enable: one pulse every fourth cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tcnt = (tcnt + 1) % 4;
            bclk_en = (tcnt == 0);
        end
    end

    // line receiver sampling at mid-bit
    int       m_st = 0;
    int       m_cnt = 0;
    int       m_bit = 0;
    logic [7:0] m_sh = 8'h00;
    always @(negedge clk) begin
        if (rst) begin
            m_st = 0;
        end else if (bclk_en) begin
            case (m_st)
                0: if (txd == 1'b0) begin
                    if (div == 1) begin m_st = 2; m_cnt = 1; m_bit = 0; end
                    else begin m_st = 1; m_cnt = div / 2 - 1; end
                end
                1: begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        if (txd == 1'b0) begin m_st = 2; m_cnt = div; m_bit = 0; end
                        else m_st = 0;
                    end
                end
                2: begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        m_sh[m_bit] = txd;
                        m_bit = m_bit + 1;
                        m_cnt = div;
                        if (m_bit == 8) m_st = 3;
                    end
                end
                default: begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        if (txd) rx_q.push_back(m_sh);
                        else frame_err = frame_err + 1;
                        m_st = 0;
                    end
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic pulse_enable();
        @(posedge clk); #1; tx_enable_cmd = 1'b1;
        @(posedge clk); #1; tx_enable_cmd = 1'b0;
    endtask

    task automatic pulse_disable();
        @(posedge clk); #1; tx_disable_cmd = 1'b1;
        @(posedge clk); #1; tx_disable_cmd = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(posedge clk); #1; thr_wr = 1'b1; thr_data = b;
        @(posedge clk); #1; thr_wr = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!bclk_en) @(negedge clk);
        end
    endtask

    task automatic wait_fall();
        @(negedge clk);
        while (txd) @(negedge clk);
    endtask

    task automatic wait_rdy();
        @(negedge clk);
        while (!tx_rdy) @(negedge clk);
    endtask

    task automatic wait_emt();
        @(negedge clk);
        while (!tx_emt) @(negedge clk);
        wait_ticks(20);
    endtask

    function automatic int mismatch_at();
        if (rx_q.size() != exp_q.size()) return -2;
        for (int i = 0; i < rx_q.size(); i++)
            if (rx_q[i] !== exp_q[i]) return i;
        return -1;
    endfunction

    task automatic compare_all(input string req);
        int m;
        m = mismatch_at();
        if (m == -2)
            chk(1'b0, req, "frame count", rx_q.size(), exp_q.size());
        else if (m >= 0)
            chk(1'b0, req, "frame byte", rx_q[m], exp_q[m]);
        else
            chk(1'b1, req, "frames", 0, 0);
    endtask

    task automatic set_mode(input bit one_x);
        mode_1x = one_x;
        div = one_x ? 1 : 16;
    endtask

    task automatic rdy_latency(input string req, input int expect_ticks);
        int n;
        wait_fall();
        n = bclk_en ? 1 : 0;
        @(negedge clk);
        while (!tx_rdy) begin
            if (bclk_en) n++;
            @(negedge clk);
        end
        chk(n == expect_ticks, req, "ticks from start edge to tx_rdy", n, expect_ticks);
    endtask

    initial begin
        void'($urandom(32'h1357));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
        chk(tx_rdy == 1'b0, "R1", "tx_rdy after reset", tx_rdy, 0);
        chk(tx_emt == 1'b1, "R1", "tx_emt after reset", tx_emt, 1);

        // R4 write while disabled ignored
        write_byte(8'h3C);
        pulse_enable();
        @(negedge clk);
        chk(tx_rdy == 1'b1, "R4", "tx_rdy after enable", tx_rdy, 1);
        chk(tx_emt == 1'b1, "R5", "tx_emt just enabled", tx_emt, 1);
        wait_ticks(200);
        chk(rx_q.size() == 0, "R4", "frames from write while disabled", rx_q.size(), 0);

        // R4 tx_rdy clears on write; R3 timing 16x; R2 frame
        @(posedge clk); #1; thr_wr = 1'b1; thr_data = 8'hA5;
        @(posedge clk); #1; thr_wr = 1'b0;
        @(negedge clk);
        chk(tx_rdy == 1'b0, "R4", "tx_rdy after write", tx_rdy, 0);
        chk(tx_emt == 1'b0, "R5", "tx_emt with byte pending", tx_emt, 0);
        exp_q.push_back(8'hA5);
        rdy_latency("R3", 16);
        wait_emt();
        compare_all("R2");
        chk(tx_emt == 1'b1 && txd == 1'b1, "R5", "tx_emt after underrun", tx_emt, 1);

        // R6 disable immediately after load in underrun
        write_byte(8'h81);
        pulse_disable();
        wait_ticks(200);
        compare_all("R6");
        chk(txd == 1'b1, "R6", "line after discard", txd, 1);
        chk(tx_rdy == 1'b0, "R4", "tx_rdy while disabled", tx_rdy, 0);

        // R6 disable inside start bit before copy point (16x)
        pulse_enable();
        write_byte(8'h42);
        wait_fall();
        pulse_disable();
        @(negedge clk);
        chk(txd == 1'b1, "R6", "line returns to mark on abort", txd, 1);
        wait_ticks(200);
        compare_all("R6");

        // R7 disable after copy point, still in start bit
        pulse_enable();
        write_byte(8'h5A);
        exp_q.push_back(8'h5A);
        wait_fall();
        wait_ticks(5);
        pulse_disable();
        wait_emt();
        compare_all("R7");

        // R7 pending holding byte dropped, shifting byte completes
        pulse_enable();
        write_byte(8'hC3);
        exp_q.push_back(8'hC3);
        wait_rdy();
        write_byte(8'h99);
        pulse_disable();
        wait_emt();
        wait_ticks(200);
        compare_all("R7");

        // R8 CTS gating
        pulse_enable();
        cts_ctrl = 1'b1;
        cts_n = 1'b1;
        write_byte(8'h17);
        wait_ticks(200);
        chk(rx_q.size() == exp_q.size(), "R8", "frames while cts high", rx_q.size(), exp_q.size());
        chk(tx_emt == 1'b0, "R8", "tx_emt with byte held", tx_emt, 0);
        cts_n = 1'b0;
        exp_q.push_back(8'h17);
        wait_emt();
        compare_all("R8");
        // cts rises mid-frame
        write_byte(8'h6E);
        exp_q.push_back(8'h6E);
        wait_rdy();
        write_byte(8'hB2);
        wait_ticks(40);
        cts_n = 1'b1;
        wait_ticks(400);
        compare_all("R8");
        chk(txd == 1'b1 && tx_emt == 1'b0, "R8", "second byte held", tx_emt, 0);
        cts_n = 1'b0;
        exp_q.push_back(8'hB2);
        wait_emt();
        compare_all("R8");

        // R9 cts ignored when control off
        cts_ctrl = 1'b0;
        cts_n = 1'b1;
        write_byte(8'hE1);
        exp_q.push_back(8'hE1);
        wait_emt();
        compare_all("R9");
        cts_n = 1'b0;

        // random stream, 16x
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            wait_rdy();
            repeat ($urandom % 3) @(posedge clk);
            write_byte(b);
            exp_q.push_back(b);
        end
        wait_emt();
        compare_all("R2");

        // 1x mode
        pulse_disable();
        set_mode(1'b1);
        pulse_enable();
        write_byte(8'h2D);
        exp_q.push_back(8'h2D);
        rdy_latency("R3", 1);
        wait_emt();
        compare_all("R2");

        // R6 1x: disable before the start bit's pulse
        write_byte(8'h77);
        wait_fall();
        pulse_disable();
        wait_ticks(40);
        compare_all("R6");
        pulse_enable();

        for (int i = 0; i < 12; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            wait_rdy();
            write_byte(b);
            exp_q.push_back(b);
        end
        wait_emt();
        compare_all("R2");
        chk(frame_err == 0, "R2", "stop bit errors", frame_err, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule